// File: doc/BRIEF.md
# Mixed-Direction GPIO Port Register Block

This block is a small memory-mapped general-purpose I/O port with four pins. The three low pins can each be an input or an output; the fourth pin is input-only. Software reaches it through a simple register bus with an address, a write strobe, write data, a read strobe and registered read data. Two registers sit on that bus: a data register and a write-only direction register. The block drives an output value and an output enable for each bidirectional pin. It samples all four pin inputs through a two-flop synchronizer.

Reading the data register gives a per-bit view. A bidirectional bit set as an output returns the value software last wrote. A bit set as an input returns the synchronized level on the pin. The input-only bit always returns its pin. The unused high bits always read as ones. The direction register cannot be read back: any read of its address returns all ones.

A per-pin select input comes from a separate serial-control block. When a pin's select is low, that pin belongs to a peripheral, and this block keeps that pin's output enable low. The direction and data settings are still kept, so they take effect again when the select returns high.

Top module: `gpio_mixport`

## Requirements
- R1: After reset the output enables and output values are all 0, and a data-register read with the input-only pin high and the other pins low returns 0xF8.
- R2: A read of the direction register address (1), or of any address other than the data register address (0), returns 0xFF, whatever has been written.
- R3: For a bidirectional bit i (bits 2..0) whose direction bit is 1, a data-register read returns the last written data bit i, even when the pin is held at the opposite level.
- R4: For a bidirectional bit i whose direction bit is 0, a data-register read returns the synchronized level of pin i.
- R5: Data-register bit 3 always returns the synchronized level of the input-only pin (pin_in[3]), and writes to bit 3 have no effect.
- R6: Data-register bits 7..4 always read as 1, and writes of any value to them have no effect.
- R7: pin_out[i] equals the last written data bit i. pin_oe[i] is 1 only when both direction bit i and gpio_sel[i] are 1.
- R8: A pin change applied between clock edges shows up in a read whose capture edge is the third edge after the change, and not in reads captured at the first or second edge.
- R9: bus_rdata is loaded at the clock edge where bus_re is high and holds its value while bus_re is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: 0 is data, 1 is direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered one cycle after bus_re |
| pin_in | input | N_IO+1 | Pin levels; bit N_IO is the input-only pin |
| gpio_sel | input | N_IO | 1 hands pin i to general I/O |
| pin_out | output | N_IO | Output value per bidirectional pin |
| pin_oe | output | N_IO | Output enable per bidirectional pin |

## Verification
The assertions take for granted that the bus never writes and reads the data register in the same cycle. They also assume that pin_in is stable for at least three edges after reset before its bit-3 latency relation is checked. The read-back and output-mode relations are checked only when no write is in flight. The bench drives every bus operation as a single-strobe cycle at the falling edge and never overlaps a read with a write. It changes pin levels only between edges, and waits three cycles after a pin change before any read that does not measure latency.

// File: rtl/gpio_mixport_pkg.sv
package gpio_mixport_pkg;
   localparam int unsigned REG_W = 8;
   typedef logic [REG_W-1:0] reg_t;
   localparam reg_t ALL_ONES = '1;
endpackage

// File: rtl/gpio_mixport_sync.sv
module gpio_mixport_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[k] <= '0;
         else        stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mixport_regs.sv
module gpio_mixport_regs #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_ADDR = 0,
   parameter int unsigned DIR_ADDR  = 1,
   parameter int unsigned N_IO      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [N_IO-1:0]   wr_bits,
   output logic [N_IO-1:0]   lat_q,
   output logic [N_IO-1:0]   dir_q
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);

   logic wr_data, wr_dir;
   assign wr_data = bus_we && (bus_addr == A_DATA);
   assign wr_dir  = bus_we && (bus_addr == A_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '0;
      end else begin
         if (wr_data) lat_q <= wr_bits;
         if (wr_dir)  dir_q <= wr_bits;
      end
   end
endmodule

// File: rtl/gpio_mixport_rdmux.sv
module gpio_mixport_rdmux
   import gpio_mixport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_ADDR = 0,
   parameter int unsigned N_IO      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_IO-1:0]   lat_q,
   input  logic [N_IO-1:0]   dir_q,
   input  logic [N_IO:0]     pin_sync,
   output reg_t              bus_rdata
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

   reg_t data_view;

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i < N_IO) begin : g_bidir
         assign data_view[i] = dir_q[i] ? lat_q[i] : pin_sync[i];
      end else if (i == N_IO) begin : g_inonly
         assign data_view[i] = pin_sync[N_IO];
      end else begin : g_unused
         assign data_view[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= (bus_addr == A_DATA) ? data_view : ALL_ONES;
   end
endmodule

// File: rtl/gpio_mixport.sv
module gpio_mixport
   import gpio_mixport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_ADDR   = 0,
   parameter int unsigned DIR_ADDR    = 1,
   parameter int unsigned N_IO        = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   input  logic [N_IO:0]     pin_in,
   input  logic [N_IO-1:0]   gpio_sel,
   output logic [N_IO-1:0]   pin_out,
   output logic [N_IO-1:0]   pin_oe
);
   localparam int unsigned N_PIN = N_IO + 1;

   if (N_PIN > REG_W) begin : g_bad_width
      $error("gpio_mixport: N_IO+1 must fit in the register width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_mixport: SYNC_STAGES must be at least 2");
   end
   if (DATA_ADDR == DIR_ADDR) begin : g_bad_addr
      $error("gpio_mixport: register addresses must differ");
   end
   if (DATA_ADDR >= (1 << ADDR_W) || DIR_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("gpio_mixport: register address exceeds ADDR_W");
   end

   logic [N_IO-1:0]  lat_q;
   logic [N_IO-1:0]  dir_q;
   logic [N_PIN-1:0] pin_sync;

   gpio_mixport_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_mixport_regs #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .N_IO(N_IO)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .wr_bits  (bus_wdata[N_IO-1:0]),
      .lat_q    (lat_q),
      .dir_q    (dir_q)
   );

   gpio_mixport_rdmux #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .N_IO(N_IO)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_re    (bus_re),
      .bus_addr  (bus_addr),
      .lat_q     (lat_q),
      .dir_q     (dir_q),
      .pin_sync  (pin_sync),
      .bus_rdata (bus_rdata)
   );

   for (genvar i = 0; i < N_IO; i++) begin : g_pin
      assign pin_out[i] = lat_q[i];
      assign pin_oe[i]  = dir_q[i] & gpio_sel[i];
   end
endmodule

// File: rtl/gpio_mixport_chk.sv
module gpio_mixport_chk #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_ADDR   = 0,
   parameter int unsigned N_IO        = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              bus_re,
   input logic [7:0]        bus_rdata,
   input logic [N_IO:0]     pin_in,
   input logic [N_IO-1:0]   gpio_sel,
   input logic [N_IO-1:0]   pin_out,
   input logic [N_IO-1:0]   pin_oe,
   input logic [N_IO-1:0]   dir_q
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   logic rd_data, rd_other;
   assign rd_data  = bus_re && (bus_addr == A_DATA) && !bus_we;
   assign rd_other = bus_re && (bus_addr != A_DATA);

   // R2
   other_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_other |=> bus_rdata == 8'hFF);

   // R6
   upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |=> bus_rdata[7:4] == 4'hF);

   // R3
   out_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |=> ((bus_rdata[N_IO-1:0] ^ $past(pin_out)) & $past(dir_q)) == '0);

   // R7
   oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~gpio_sel) == '0);

   // R7
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~dir_q) == '0);

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   if (SYNC_STAGES == 2) begin : g_lat
      // R5
      inonly_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data && age == 2'd3) |=> bus_rdata[N_IO] == $past(pin_in[N_IO], 3));
   end
endmodule

bind gpio_mixport gpio_mixport_chk #(
   .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .N_IO(N_IO), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .gpio_sel  (gpio_sel),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .dir_q     (dir_q)
);

// File: tb/sim_gpio_mixport.sv
`timescale 1ns/1ps
module sim_gpio_mixport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_re = 1'b0;
   logic [7:0] bus_rdata;
   logic [3:0] pin_in = 4'b1000;
   logic [2:0] gpio_sel = 3'b111;
   logic [2:0] pin_out;
   logic [2:0] pin_oe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gpio_mixport u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .gpio_sel(gpio_sel), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [3:0] p);
      @(negedge clk);
      pin_in = p;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R1 oe", {5'b0, pin_oe}, 8'h00);
      check("R1 out", {5'b0, pin_out}, 8'h00);
      rd(4'd0, v);
      check("R1 data", v, 8'hF8);
   endtask

   task automatic t_dir_read;
      logic [7:0] v;
      wr(4'd1, 8'h05);
      rd(4'd1, v);
      check("R2 dir after 0x05", v, 8'hFF);
      wr(4'd1, 8'h00);
      rd(4'd1, v);
      check("R2 dir after 0x00", v, 8'hFF);
      rd(4'd5, v);
      check("R2 unmapped", v, 8'hFF);
   endtask

   task automatic t_input_mode;
      logic [7:0] v;
      wr(4'd0, 8'h07);
      set_pins(4'b0101);
      rd(4'd0, v);
      check("R4 pins 0101", v, 8'hF5);
      set_pins(4'b1010);
      rd(4'd0, v);
      check("R4 pins 1010", v, 8'hFA);
   endtask

   task automatic t_output_mode;
      logic [7:0] v;
      wr(4'd0, 8'h05);
      wr(4'd1, 8'h07);
      set_pins(4'b0010);
      rd(4'd0, v);
      check("R3 opposite pins", v, 8'hF5);
      check("R7 out", {5'b0, pin_out}, 8'h05);
      check("R7 oe all sel", {5'b0, pin_oe}, 8'h07);
      @(negedge clk); gpio_sel = 3'b010; #1;
      check("R7 oe sel 010", {5'b0, pin_oe}, 8'h02);
      @(negedge clk); gpio_sel = 3'b000; #1;
      check("R7 oe no sel", {5'b0, pin_oe}, 8'h00);
      rd(4'd0, v);
      check("R3 settings kept without sel", v, 8'hF5);
      @(negedge clk); gpio_sel = 3'b111;
   endtask

   task automatic t_mixed;
      logic [7:0] v;
      wr(4'd1, 8'h01);
      wr(4'd0, 8'h07);
      set_pins(4'b1010);
      rd(4'd0, v);
      check("R3 R4 mixed", v, 8'hFB);
      check("R7 oe mixed", {5'b0, pin_oe}, 8'h01);
   endtask

   task automatic t_inonly;
      logic [7:0] v;
      wr(4'd1, 8'h07);
      set_pins(4'b0000);
      wr(4'd0, 8'h08);
      rd(4'd0, v);
      check("R5 write 1 pin 0", v, 8'hF0);
      set_pins(4'b1000);
      wr(4'd0, 8'h00);
      rd(4'd0, v);
      check("R5 write 0 pin 1", v, 8'hF8);
   endtask

   task automatic t_upper;
      logic [7:0] v;
      wr(4'd0, 8'h07);
      rd(4'd0, v);
      check("R6 write upper 0", v, 8'hFF);
      wr(4'd0, 8'hF2);
      rd(4'd0, v);
      check("R6 write upper 1", v, 8'hFA);
      check("R6 out after F2", {5'b0, pin_out}, 8'h02);
   endtask

   task automatic t_latency;
      wr(4'd1, 8'h00);
      set_pins(4'b0000);
      @(negedge clk);
      pin_in = 4'b1111; bus_addr = 4'd0; bus_re = 1'b1;
      @(negedge clk);
      check("R8 edge 1", bus_rdata, 8'hF0);
      @(negedge clk);
      check("R8 edge 2", bus_rdata, 8'hF0);
      @(negedge clk);
      check("R8 edge 3", bus_rdata, 8'hFF);
      bus_re = 1'b0;
   endtask

   task automatic t_hold;
      logic [7:0] v;
      set_pins(4'b0101);
      rd(4'd0, v);
      check("R9 loaded", v, 8'hF5);
      set_pins(4'b1010);
      check("R9 held", bus_rdata, 8'hF5);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_dir_read();
      t_input_mode();
      t_output_mode();
      t_mixed();
      t_inonly();
      t_upper();
      t_latency();
      t_hold();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule